// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a simple in-order core and a byte-addressed data memory port of `DATA_W` bits (32 by default). For a store it turns a byte address, an access size and register data into a word-aligned memory address, per-lane byte enables and write data steered onto the lanes that the access covers. For a load it takes the raw memory word, picks out the addressed byte, halfword or word, and widens the result to the full data width. Signed loads copy the field's top bit into the upper bits. Unsigned loads fill them with zeros. Lane mapping is little-endian only: the lowest address in a word sits in bits 7:0.

Accesses that are not naturally aligned are flagged and never touch memory. A trap unit or a software handler can then take over. The address is used exactly as given. The block never produces an updated base address. The memory read path is combinational from `mem_rdata_i`. Every valid request returns one registered response, one clock later. The response carries the extracted load data together with the size, signedness and misalignment of the request that produced it.

Top module: `lla_lane_align`

## Requirements
- R1: `mem_addr_o` equals `req_addr_i` with its two lowest bits forced to zero, for every request.
- R2: Size codes are 0 for byte, 1 for halfword, 2 for word and 3 for reserved. `misaligned_o` is high in the same cycle as a valid request when one of these holds: a halfword with address bit 0 set, a word with either of address bits 1:0 set, or size code 3. A byte access is never misaligned.
- R3: `mem_be_o` is zero for loads, for idle cycles and for misaligned stores. For an aligned store it is 4'b0001 shifted left by address bits 1:0 for a byte, 4'b0011 shifted left by those bits for a halfword, and 4'b1111 for a word. Bit n enables bits 8n+7:8n.
- R4: For a byte store, `mem_wdata_o` holds the low byte of `req_wdata_i` in every lane. For a halfword store it holds the low 16 bits in both halves. For a word store it holds `req_wdata_i` unchanged.
- R5: A load takes its field from `mem_rdata_i` starting at bit 8 times address bits 1:0: 8 bits for a byte, 16 bits for a halfword, 32 bits for a word.
- R6: When `req_unsigned_i` is 0, a byte or halfword load copies the top bit of its field into all upper bits. When it is 1, it fills the upper bits with zeros.
- R7: `rsp_valid_o` is high exactly in the cycle after each cycle with `req_valid_i` high. In that cycle, `rsp_size_o`, `rsp_unsigned_o` and `rsp_misaligned_o` hold the values of that request. `rsp_data_o` holds the extended load field, or zero for a store or a misaligned access.
- R8: While `rst_ni` is low, `rsp_valid_o` and all response fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_store_i | input | 1 | 1 for store, 0 for load |
| req_size_i | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 reserved) |
| req_unsigned_i | input | 1 | Zero-extend the load result |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Store data from the register |
| mem_rdata_i | input | DATA_W | Memory word at `mem_addr_o` |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_be_o | output | DATA_W/8 | Per-lane write enables |
| mem_wdata_o | output | DATA_W | Lane-steered write data |
| misaligned_o | output | 1 | Current request is not naturally aligned |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_size_o | output | 2 | Size code of that request |
| rsp_unsigned_o | output | 1 | Signedness of that request |
| rsp_misaligned_o | output | 1 | That request was misaligned |
| rsp_data_o | output | DATA_W | Extended load data, zero for stores and misaligned accesses |

## Verification
The bench builds the block with `ADDR_W` = 12 and the default 32-bit data width. A four-word memory model, indexed by address bits 3:2, can then apply the enabled writes and feed the read word back. As a result, every store can be confirmed by a later load. The stimulus covers each lane offset for byte and halfword accesses and values whose top field bit is set. It also covers misaligned stores, followed by loads showing that memory was left unchanged. Back-to-back requests and idle gaps exercise the one-cycle response pairing.

// File: rtl/lla_pkg.sv
package lla_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // lanes covered by one access of the given size
  function automatic int unsigned size_lanes(acc_size_e s);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return 4;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/lla_misalign.sv
module lla_misalign
  import lla_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  acc_size_e          size_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic               mis_o
);

  always_comb begin
    unique case (size_i)
      SZ_BYTE: mis_o = 1'b0;
      SZ_HALF: mis_o = off_i[0];
      SZ_WORD: mis_o = |off_i[1:0];
      default: mis_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/lla_store_steer.sv
module lla_store_steer
  import lla_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              en_i,
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o
);

  logic [LANES-1:0] base_mask;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: base_mask = LANES'(4'b0001);
      SZ_HALF: base_mask = LANES'(4'b0011);
      SZ_WORD: base_mask = LANES'(4'b1111);
      default: base_mask = '0;
    endcase
  end

  assign be_o = en_i ? (base_mask << off_i) : '0;

  // each lane takes the register byte that lands there for the access size
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_BYTE: wdata_o[8*j +: 8] = wdata_i[7:0];
        SZ_HALF: wdata_o[8*j +: 8] = wdata_i[8*(j % 2) +: 8];
        default: wdata_o[8*j +: 8] = wdata_i[8*(j % 4) +: 8];
      endcase
    end
  end

endmodule

// File: rtl/lla_load_extract.sv
module lla_load_extract
  import lla_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              uns_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] shifted;
  logic              sign_bit;
  logic [7:0]        fill;

  assign shifted = rdata_i >> {off_i, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: sign_bit = shifted[7];
      SZ_HALF: sign_bit = shifted[15];
      default: sign_bit = shifted[31];
    endcase
  end

  assign fill = uns_i ? 8'h00 : {8{sign_bit}};

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam bit IN_BYTE = (j < 1);
    localparam bit IN_HALF = (j < 2);
    localparam bit IN_WORD = (j < 4);
    always_comb begin
      unique case (size_i)
        SZ_BYTE: data_o[8*j +: 8] = IN_BYTE ? shifted[8*j +: 8] : fill;
        SZ_HALF: data_o[8*j +: 8] = IN_HALF ? shifted[8*j +: 8] : fill;
        default: data_o[8*j +: 8] = IN_WORD ? shifted[8*j +: 8] : fill;
      endcase
    end
  end

endmodule

// File: rtl/lla_lane_align.sv
module lla_lane_align
  import lla_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_store_i,
  input  logic [1:0]            req_size_i,
  input  logic                  req_unsigned_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [DATA_W/8-1:0]   mem_be_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  output logic                  misaligned_o,
  output logic                  rsp_valid_o,
  output logic [1:0]            rsp_size_o,
  output logic                  rsp_unsigned_o,
  output logic                  rsp_misaligned_o,
  output logic [DATA_W-1:0]     rsp_data_o
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  acc_size_e        size;
  logic [OFF_W-1:0] off;
  logic             mis;
  logic             st_en;
  logic [DATA_W-1:0] ld_data;

  assign size = acc_size_e'(req_size_i);
  assign off  = req_addr_i[OFF_W-1:0];

  // memory side always sees word-aligned addresses
  assign mem_addr_o = {req_addr_i[ADDR_W-1:2], 2'b00};

  lla_misalign #(.OFF_W(OFF_W)) u_mis (
    .size_i (size),
    .off_i  (off),
    .mis_o  (mis)
  );

  assign misaligned_o = req_valid_i & mis;
  assign st_en        = req_valid_i & req_store_i & ~mis;

  lla_store_steer #(.DATA_W(DATA_W)) u_st (
    .en_i    (st_en),
    .size_i  (size),
    .off_i   (off),
    .wdata_i (req_wdata_i),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );

  lla_load_extract #(.DATA_W(DATA_W)) u_ld (
    .size_i  (size),
    .off_i   (off),
    .uns_i   (req_unsigned_i),
    .rdata_i (mem_rdata_i),
    .data_o  (ld_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o      <= 1'b0;
      rsp_size_o       <= 2'd0;
      rsp_unsigned_o   <= 1'b0;
      rsp_misaligned_o <= 1'b0;
      rsp_data_o       <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_size_o       <= req_size_i;
        rsp_unsigned_o   <= req_unsigned_i;
        rsp_misaligned_o <= mis;
        rsp_data_o       <= (req_store_i | mis) ? '0 : ld_data;
      end
    end
  end

endmodule

// File: rtl/lla_lane_align_sva.sv
module lla_lane_align_sva #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_store_i,
  input logic [1:0]            req_size_i,
  input logic                  req_unsigned_i,
  input logic [ADDR_W-1:0]     req_addr_i,
  input logic [DATA_W-1:0]     req_wdata_i,
  input logic [DATA_W-1:0]     mem_rdata_i,
  input logic [ADDR_W-1:0]     mem_addr_o,
  input logic [DATA_W/8-1:0]   mem_be_o,
  input logic [DATA_W-1:0]     mem_wdata_o,
  input logic                  misaligned_o,
  input logic                  rsp_valid_o,
  input logic [1:0]            rsp_size_o,
  input logic                  rsp_unsigned_o,
  input logic                  rsp_misaligned_o,
  input logic [DATA_W-1:0]     rsp_data_o
);

  a_r2_half_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == 2'd1 && req_addr_i[0]) |-> misaligned_o);

  a_r2_byte_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == 2'd0) |-> !misaligned_o);

  a_r3_no_be_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misaligned_o |-> mem_be_o == '0);

  a_r3_no_be_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_store_i) |-> mem_be_o == '0);

  a_r3_byte_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i && req_size_i == 2'd0) |-> $countones(mem_be_o) == 1);

  a_r3_word_four_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i && req_size_i == 2'd2 && !misaligned_o)
      |-> $countones(mem_be_o) == 4);

  a_r7_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r7_no_rsp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r7_mis_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_misaligned_o == $past(misaligned_o));

  a_r6_signed_byte_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_unsigned_o && rsp_size_o == 2'd0)
      |-> rsp_data_o[DATA_W-1:8] == {(DATA_W-8){rsp_data_o[7]}});

  a_r6_unsigned_half_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_unsigned_o && rsp_size_o == 2'd1)
      |-> rsp_data_o[DATA_W-1:16] == '0);

endmodule

bind lla_lane_align lla_lane_align_sva #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/lla_lane_align_test.sv
module lla_lane_align_test;

  localparam int DW = 32;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_store = 1'b0, req_uns = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [DW-1:0] mem_wdata;
  logic          misaligned, rsp_valid, rsp_uns, rsp_mis;
  logic [1:0]    rsp_size;
  logic [DW-1:0] rsp_data;

  lla_lane_align #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_store_i(req_store), .req_size_i(req_size),
    .req_unsigned_i(req_uns), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .misaligned_o(misaligned),
    .rsp_valid_o(rsp_valid), .rsp_size_o(rsp_size), .rsp_unsigned_o(rsp_uns),
    .rsp_misaligned_o(rsp_mis), .rsp_data_o(rsp_data)
  );

  // four-word memory model
  logic [DW-1:0] mem [4];
  initial for (int i = 0; i < 4; i++) mem[i] = '0;
  assign mem_rdata = mem[req_addr[3:2]];
  always @(posedge clk)
    for (int l = 0; l < 4; l++)
      if (mem_be[l]) mem[req_addr[3:2]][8*l +: 8] <= mem_wdata[8*l +: 8];

  typedef struct packed {
    logic [1:0]    size;
    logic          uns;
    logic          mis;
    logic [DW-1:0] data;
  } exp_t;
  exp_t exp_q[$];

  int total = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  function automatic logic emis(input logic [1:0] s, input logic [1:0] a);
    case (s)
      2'd0: return 1'b0;
      2'd1: return a[0];
      2'd2: return a != 2'd0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [3:0] ebe(input logic st, input logic [1:0] s,
                                     input logic [1:0] a);
    if (!st || emis(s, a)) return 4'b0000;
    case (s)
      2'd0: return 4'b0001 << a;
      2'd1: return 4'b0011 << a;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [DW-1:0] ewd(input logic [1:0] s, input logic [DW-1:0] d);
    case (s)
      2'd0: return {4{d[7:0]}};
      2'd1: return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [DW-1:0] eld(input logic [1:0] s, input logic u,
                                        input logic [DW-1:0] w, input logic [1:0] a);
    logic [DW-1:0] sh;
    sh = w >> (8 * a);
    case (s)
      2'd0: return u ? {24'd0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
      2'd1: return u ? {16'd0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
      default: return sh;
    endcase
  endfunction

  // driver: one request per call, comb outputs checked, response pushed
  task automatic drive(input logic st, input logic [1:0] s, input logic u,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_t e;
    logic m;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = s; req_uns = u;
    req_addr = a; req_wdata = d;
    #1;
    m = emis(s, a[1:0]);
    chk(mem_addr == {a[AW-1:2], 2'b00}, "R1 word address", DW'(mem_addr),
        DW'({a[AW-1:2], 2'b00}));
    chk(misaligned == m, "R2 misaligned flag", DW'(misaligned), DW'(m));
    chk(mem_be == ebe(st, s, a[1:0]), "R3 byte enables", DW'(mem_be),
        DW'(ebe(st, s, a[1:0])));
    if (st && !m) chk(mem_wdata == ewd(s, d), "R4 write data", mem_wdata, ewd(s, d));
    e.size = s; e.uns = u; e.mis = m;
    e.data = (st || m) ? '0 : eld(s, u, mem[a[3:2]], a[1:0]);
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor: pairs each response with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected response", rsp_data, '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_data == e.data, "R5 R6 response data", rsp_data, e.data);
        chk(rsp_size == e.size && rsp_uns == e.uns, "R7 size/sign tag",
            DW'({rsp_size, rsp_uns}), DW'({e.size, e.uns}));
        chk(rsp_mis == e.mis, "R7 misaligned tag", DW'(rsp_mis), DW'(e.mis));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0 && rsp_data == '0 && rsp_size == 2'd0,
        "R8 reset response", rsp_data, '0);
    chk(mem_be == 4'd0, "R8 reset enables", DW'(mem_be), '0);
    rst_n = 1'b1;

    // R3 R4 aligned stores of each size
    drive(1'b1, 2'd2, 1'b0, 12'h000, 32'h8899_AABB);
    drive(1'b1, 2'd2, 1'b0, 12'h004, 32'h0000_0000);
    drive(1'b1, 2'd0, 1'b0, 12'h005, 32'h1234_565A);
    drive(1'b1, 2'd1, 1'b0, 12'h006, 32'hDEAD_F00D);
    // R5 R6 loads at each lane, signed and unsigned
    drive(1'b0, 2'd0, 1'b0, 12'h003, '0);
    drive(1'b0, 2'd0, 1'b1, 12'h003, '0);
    drive(1'b0, 2'd0, 1'b0, 12'h000, '0);
    drive(1'b0, 2'd0, 1'b0, 12'h005, '0);
    drive(1'b0, 2'd1, 1'b0, 12'h002, '0);
    drive(1'b0, 2'd1, 1'b1, 12'h002, '0);
    drive(1'b0, 2'd1, 1'b0, 12'h000, '0);
    drive(1'b0, 2'd1, 1'b0, 12'h006, '0);
    drive(1'b0, 2'd2, 1'b0, 12'h004, '0);
    idle(2);
    chk(rsp_valid == 1'b0, "R7 no response when idle", DW'(rsp_valid), '0);
    // R2 R3 misaligned stores leave memory untouched
    drive(1'b1, 2'd1, 1'b0, 12'h001, 32'hFFFF_FFFF);
    drive(1'b1, 2'd2, 1'b0, 12'h002, 32'hFFFF_FFFF);
    drive(1'b1, 2'd3, 1'b0, 12'h000, 32'hFFFF_FFFF);
    drive(1'b0, 2'd2, 1'b0, 12'h000, '0);
    drive(1'b0, 2'd2, 1'b0, 12'h003, '0);
    drive(1'b0, 2'd1, 1'b1, 12'h007, '0);
    // R3 byte store at every lane of one word, then readback
    for (int k = 0; k < 4; k++)
      drive(1'b1, 2'd0, 1'b0, 12'h008 + 12'(k), 32'h0000_00F0 + 32'(k));
    drive(1'b0, 2'd2, 1'b0, 12'h008, '0);
    drive(1'b1, 2'd1, 1'b0, 12'h00E, 32'h0000_7FFE);
    drive(1'b0, 2'd1, 1'b0, 12'h00E, '0);
    drive(1'b0, 2'd0, 1'b0, 12'h00B, '0);
    idle(3);
    chk(exp_q.size() == 0, "R7 all responses seen", DW'(exp_q.size()), '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule